// File: doc/BRIEF.md
# Square-Pixel Embedded-Sync Line Timing Generator

This block produces a continuous stream of 8-bit multiplexed 4:2:2 video bytes for square-pixel standard-definition timing. Every line starts with an end-of-active-video timing code. A horizontal blanking fill follows, then a start-of-active-video timing code, then the active samples. A system select picks between the 525-line/60 Hz geometry and the 625-line/50 Hz geometry. In the 525-line system the line has 272 blanking clocks and 1280 active clocks; the 625-line system uses 344 and 1536. A progressive-mode input switches from two interlaced fields per frame to a single progressive frame of the first field's length. The line timing stays the same in both modes.

An internal line counter derives the field flag and the vertical-blanking flag that go into each timing code's status byte. An upstream source supplies active samples in the order Cb, Y, Cr, Y through a ready/valid port. When a sample is missing, the block inserts the black level. It also clamps samples so that they can never imitate a timing code. A one-clock HSYNC pulse and an active-video flag accompany the byte stream. All three outputs are registered.

Top module: `sqp_line_gen`

## Requirements
- R1: Each line opens with the bytes 0xFF, 0x00, 0x00 and a status byte at line positions 0 to 3. The same four-byte pattern appears again at positions 4+BLANK to 7+BLANK.
- R2: BLANK is 272 and the active length is 1280 for system select 0 (525-line). For system select 1 (625-line) they are 344 and 1536. A line is 8+BLANK+ACTIVE clocks, and `active` is high exactly on the active positions.
- R3: Blanking positions 4 to 3+BLANK carry 0x80 at even positions and 0x10 at odd positions, so the fill starts with 0x80.
- R4: `pix_ready` is high exactly while the line position is in the active region. One sample is taken on every clock where ready and valid are both high, and it appears on `vid_byte` one clock later.
- R5: An active slot with `pix_valid` low carries black: 0x80 at even offsets from the active start (Cb/Cr slots) and 0x10 at odd offsets (Y slots).
- R6: An accepted sample of 0x00 is sent as 0x01, and 0xFF is sent as 0xFE. Other values pass unchanged.
- R7: The status byte is {1, F, V, H, V^H, F^H, F^V, F^V^H} from bit 7 down to bit 0. H is 1 in the first code of the line and 0 in the second.
- R8: In interlaced mode, F is 1 on frame lines at or after the second-field start (263 or 313). V is 1 on the first 20 or 25 lines of each field. The frame has 525 or 625 lines.
- R9: In progressive mode, F is always 0, the frame length equals the second-field start line count, and V is 1 on its first VBL lines.
- R10: `hsync` is a one-clock pulse on every line. It comes 236 clocks (525-line) or 308 clocks (625-line) before the first active byte.
- R11: The system select and progressive-mode inputs are sampled during reset and at the end of the last line of a frame, and at no other time.
- R12: During reset, `vid_byte` is 0x80 and `hsync`, `active` and `pix_ready` are 0. The first byte after reset is the 0xFF of line 0. Every byte appears one clock after its line position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_sel | input | 1 | 0 selects the 525-line system, 1 selects the 625-line system |
| prog_en | input | 1 | 1 selects progressive (noninterlaced) frames |
| pix_data | input | 8 | Active sample from upstream |
| pix_valid | input | 1 | `pix_data` holds a sample |
| pix_ready | output | 1 | Block takes a sample this clock if valid |
| vid_byte | output | 8 | Multiplexed byte stream with embedded codes |
| hsync | output | 1 | One-clock line sync pulse |
| active | output | 1 | `vid_byte` carries an active-region slot |

## Verification
The properties assume that upstream respects the handshake. They also assume that nothing outside the block forces the byte stream. With those assumptions, the only bytes that can follow 0xFF, 0x00, 0x00 are status bytes. This holds because fill and clamped samples never form that triple. The bench uses reduced blanking, active and line counts so that whole frames of both systems fit in a short run. It changes the mode inputs only at negative clock edges, in the middle of a frame, so that the frame-boundary sampling is exercised. Valid is dropped on a fixed cadence, and the data counter passes through 0x00 and 0xFF.

// File: rtl/sqp_pkg.sv
package sqp_pkg;
  typedef enum logic {SYS_525 = 1'b0, SYS_625 = 1'b1} sys_e;

  localparam logic [7:0] CODE_HI = 8'hFF;
  localparam logic [7:0] CODE_LO = 8'h00;
  localparam logic [7:0] BLACK_C = 8'h80;
  localparam logic [7:0] BLACK_Y = 8'h10;

  // status word: fixed one, field, vblank, hcode, then four check bits
  function automatic logic [7:0] status_word(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  // keep samples out of the code-reserved values
  function automatic logic [7:0] clamp_sample(input logic [7:0] d);
    if (d == CODE_HI) return 8'hFE;
    if (d == CODE_LO) return 8'h01;
    return d;
  endfunction
endpackage

// File: rtl/sqp_hcount.sv
module sqp_hcount
  import sqp_pkg::*;
#(
  parameter int LEN_A = 1560,
  parameter int LEN_B = 1888,
  parameter int HW    = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  sys_e          sys,
  output logic [HW-1:0] pos,
  output logic          line_end
);
  logic [HW-1:0] last_pos;

  always_comb begin
    last_pos = (sys == SYS_625) ? HW'(LEN_B - 1) : HW'(LEN_A - 1);
    line_end = (pos == last_pos);
  end

  always_ff @(posedge clk) begin
    if (rst)           pos <= '0;
    else if (line_end) pos <= '0;
    else               pos <= pos + 1'b1;
  end
endmodule

// File: rtl/sqp_vcount.sv
module sqp_vcount
  import sqp_pkg::*;
#(
  parameter int TOT_A = 525,
  parameter int F1_A  = 263,
  parameter int VBL_A = 20,
  parameter int TOT_B = 625,
  parameter int F1_B  = 313,
  parameter int VBL_B = 25,
  parameter int LW    = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic line_end,
  input  logic sys_in,
  input  logic prog_in,
  output sys_e sys,
  output logic field,
  output logic vblank
);
  logic [LW-1:0] line;
  logic          prog;
  logic [LW-1:0] f1_start, frame_len, fline, vbl_len;
  logic          last_line;

  always_comb begin
    if (sys == SYS_625) begin
      f1_start = LW'(F1_B);
      vbl_len  = LW'(VBL_B);
      frame_len = prog ? LW'(F1_B) : LW'(TOT_B);
    end else begin
      f1_start = LW'(F1_A);
      vbl_len  = LW'(VBL_A);
      frame_len = prog ? LW'(F1_A) : LW'(TOT_A);
    end
    last_line = (line == frame_len - 1'b1);
    field     = !prog && (line >= f1_start);
    fline     = field ? (line - f1_start) : line;
    vblank    = (fline < vbl_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line <= '0;
      sys  <= sys_e'(sys_in);
      prog <= prog_in;
    end else if (line_end) begin
      if (last_line) begin
        line <= '0;
        sys  <= sys_e'(sys_in);
        prog <= prog_in;
      end else begin
        line <= line + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sqp_byte_mux.sv
module sqp_byte_mux
  import sqp_pkg::*;
#(
  parameter int BLANK_A = 272,
  parameter int ACT_A   = 1280,
  parameter int LEAD_A  = 236,
  parameter int BLANK_B = 344,
  parameter int ACT_B   = 1536,
  parameter int LEAD_B  = 308,
  parameter int HW      = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] pos,
  input  sys_e          sys,
  input  logic          field,
  input  logic          vblank,
  input  logic [7:0]    pix_data,
  input  logic          pix_valid,
  output logic          pix_ready,
  output logic [7:0]    vid_byte,
  output logic          hsync,
  output logic          active
);
  localparam int SAV_A = 4 + BLANK_A;
  localparam int SAV_B = 4 + BLANK_B;
  localparam int ACP_A = SAV_A + 4;
  localparam int ACP_B = SAV_B + 4;
  localparam int HSP_A = ACP_A - LEAD_A;
  localparam int HSP_B = ACP_B - LEAD_B;

  logic [HW-1:0] sav_pos, act_pos, hs_pos;
  logic          in_act, chroma_slot;
  logic [7:0]    nxt_byte;

  always_comb begin
    if (sys == SYS_625) begin
      sav_pos = HW'(SAV_B);
      act_pos = HW'(ACP_B);
      hs_pos  = HW'(HSP_B);
    end else begin
      sav_pos = HW'(SAV_A);
      act_pos = HW'(ACP_A);
      hs_pos  = HW'(HSP_A);
    end
    in_act      = (pos >= act_pos);
    chroma_slot = (pos[0] == act_pos[0]);
    pix_ready   = in_act;

    if (pos == HW'(0))                nxt_byte = CODE_HI;
    else if (pos < HW'(3))            nxt_byte = CODE_LO;
    else if (pos == HW'(3))           nxt_byte = status_word(field, vblank, 1'b1);
    else if (pos < sav_pos)           nxt_byte = pos[0] ? BLACK_Y : BLACK_C;
    else if (pos == sav_pos)          nxt_byte = CODE_HI;
    else if (pos < sav_pos + HW'(3))  nxt_byte = CODE_LO;
    else if (pos == sav_pos + HW'(3)) nxt_byte = status_word(field, vblank, 1'b0);
    else if (pix_valid)               nxt_byte = clamp_sample(pix_data);
    else                              nxt_byte = chroma_slot ? BLACK_C : BLACK_Y;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_byte <= BLACK_C;
      hsync    <= 1'b0;
      active   <= 1'b0;
    end else begin
      vid_byte <= nxt_byte;
      hsync    <= (pos == hs_pos);
      active   <= in_act;
    end
  end
endmodule

// File: rtl/sqp_line_gen.sv
module sqp_line_gen
  import sqp_pkg::*;
#(
  parameter int BLANK_A = 272,
  parameter int ACT_A   = 1280,
  parameter int LEAD_A  = 236,
  parameter int TOT_A   = 525,
  parameter int F1_A    = 263,
  parameter int VBL_A   = 20,
  parameter int BLANK_B = 344,
  parameter int ACT_B   = 1536,
  parameter int LEAD_B  = 308,
  parameter int TOT_B   = 625,
  parameter int F1_B    = 313,
  parameter int VBL_B   = 25
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sys_sel,
  input  logic       prog_en,
  input  logic [7:0] pix_data,
  input  logic       pix_valid,
  output logic       pix_ready,
  output logic [7:0] vid_byte,
  output logic       hsync,
  output logic       active
);
  localparam int LEN_A   = 8 + BLANK_A + ACT_A;
  localparam int LEN_B   = 8 + BLANK_B + ACT_B;
  localparam int LEN_MAX = (LEN_A > LEN_B) ? LEN_A : LEN_B;
  localparam int TOT_MAX = (TOT_A > TOT_B) ? TOT_A : TOT_B;
  localparam int HW      = $clog2(LEN_MAX + 1);
  localparam int LW      = $clog2(TOT_MAX + 1);

  sys_e          cur_sys;
  logic [HW-1:0] pos;
  logic          line_end, field, vblank;

  sqp_hcount #(.LEN_A(LEN_A), .LEN_B(LEN_B), .HW(HW)) u_hcount (
    .clk(clk), .rst(rst), .sys(cur_sys), .pos(pos), .line_end(line_end)
  );

  sqp_vcount #(
    .TOT_A(TOT_A), .F1_A(F1_A), .VBL_A(VBL_A),
    .TOT_B(TOT_B), .F1_B(F1_B), .VBL_B(VBL_B), .LW(LW)
  ) u_vcount (
    .clk(clk), .rst(rst), .line_end(line_end), .sys_in(sys_sel),
    .prog_in(prog_en), .sys(cur_sys), .field(field), .vblank(vblank)
  );

  sqp_byte_mux #(
    .BLANK_A(BLANK_A), .ACT_A(ACT_A), .LEAD_A(LEAD_A),
    .BLANK_B(BLANK_B), .ACT_B(ACT_B), .LEAD_B(LEAD_B), .HW(HW)
  ) u_mux (
    .clk(clk), .rst(rst), .pos(pos), .sys(cur_sys), .field(field),
    .vblank(vblank), .pix_data(pix_data), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .vid_byte(vid_byte), .hsync(hsync), .active(active)
  );
endmodule

// File: rtl/sqp_line_gen_chk.sv
module sqp_line_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       pix_ready,
  input logic [7:0] vid_byte,
  input logic       hsync,
  input logic       active
);
  a_r10_hsync_one_clock: assert property (@(posedge clk) disable iff (rst)
    hsync |=> !hsync);

  a_r10_hsync_in_blank: assert property (@(posedge clk) disable iff (rst)
    hsync |-> !active);

  a_r4_ready_then_active: assert property (@(posedge clk) disable iff (rst)
    pix_ready |=> active);

  a_r6_active_not_code: assert property (@(posedge clk) disable iff (rst)
    active |-> (vid_byte != 8'hFF && vid_byte != 8'h00));

  a_r7_status_protect: assert property (@(posedge clk) disable iff (rst)
    ($past(vid_byte, 3) == 8'hFF && $past(vid_byte, 2) == 8'h00 && $past(vid_byte, 1) == 8'h00)
    |-> (vid_byte[7] &&
         vid_byte[3] == (vid_byte[5] ^ vid_byte[4]) &&
         vid_byte[2] == (vid_byte[6] ^ vid_byte[4]) &&
         vid_byte[1] == (vid_byte[6] ^ vid_byte[5]) &&
         vid_byte[0] == (vid_byte[6] ^ vid_byte[5] ^ vid_byte[4])));
endmodule

bind sqp_line_gen sqp_line_gen_chk u_chk (
  .clk(clk), .rst(rst), .pix_ready(pix_ready), .vid_byte(vid_byte),
  .hsync(hsync), .active(active)
);

// File: tb/sqp_line_gen_bench.sv
module sqp_line_gen_bench;
  localparam int BA = 8,  AA = 8,  LA = 6,  TA = 10, FA = 5, VA = 2;
  localparam int BB = 12, AB = 12, LB = 10, TB = 12, FB = 6, VB = 2;

  logic clk = 0, rst = 1, sys_sel = 0, prog_en = 0, pix_valid = 0;
  logic [7:0] pix_data = 0;
  logic pix_ready, hsync, active;
  logic [7:0] vid_byte;

  int checks = 0, failures = 0;
  int m_pos, m_line, cyc = 0, dcnt = 0;
  logic m_sys, m_prog, have_exp = 0;
  logic [7:0] e_byte;
  logic e_hs, e_act;
  string e_tag;

  always #4 clk = ~clk;

  sqp_line_gen #(
    .BLANK_A(BA), .ACT_A(AA), .LEAD_A(LA), .TOT_A(TA), .F1_A(FA), .VBL_A(VA),
    .BLANK_B(BB), .ACT_B(AB), .LEAD_B(LB), .TOT_B(TB), .F1_B(FB), .VBL_B(VB)
  ) u_sqp_line_gen (
    .clk(clk), .rst(rst), .sys_sel(sys_sel), .prog_en(prog_en),
    .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .vid_byte(vid_byte), .hsync(hsync), .active(active)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] sw(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  // one model step at a negative edge: check previous expectation, predict next
  task automatic step();
    int blank, len, sav, actp, hsp, f1, vbl, flen, fl;
    logic f, v, rdy;
    blank = m_sys ? BB : BA;
    len   = 8 + blank + (m_sys ? AB : AA);
    sav   = 4 + blank;
    actp  = sav + 4;
    hsp   = actp - (m_sys ? LB : LA);
    f1    = m_sys ? FB : FA;
    vbl   = m_sys ? VB : VA;
    flen  = m_prog ? f1 : (m_sys ? TB : TA);
    if (have_exp) begin
      chk(e_tag, vid_byte, e_byte);
      chk("R10 hsync", hsync, e_hs);
      chk("R2 active", active, e_act);
    end
    pix_valid = ((cyc % 7) != 3);
    pix_data  = 8'(dcnt * 17);
    rdy = (m_pos >= actp);
    chk("R4 pix_ready", pix_ready, rdy);
    f  = !m_prog && (m_line >= f1);
    fl = f ? m_line - f1 : m_line;
    v  = (fl < vbl);
    if (m_pos == 0 || m_pos == sav) begin e_byte = 8'hFF; e_tag = "R1 code"; end
    else if (m_pos < 3 || (m_pos > sav && m_pos < sav + 3)) begin e_byte = 8'h00; e_tag = "R1 code"; end
    else if (m_pos == 3 || m_pos == sav + 3) begin
      e_byte = sw(f, v, m_pos == 3);
      e_tag = m_prog ? "R7 R9 status" : "R7 R8 status";
    end
    else if (m_pos < sav) begin e_byte = m_pos[0] ? 8'h10 : 8'h80; e_tag = "R3 fill"; end
    else if (pix_valid) begin
      e_byte = (pix_data == 8'hFF) ? 8'hFE : (pix_data == 8'h00) ? 8'h01 : pix_data;
      e_tag = (pix_data == 8'hFF || pix_data == 8'h00) ? "R6 clamp" : "R4 sample";
      dcnt++;
    end else begin
      e_byte = (((m_pos - actp) % 2) == 0) ? 8'h80 : 8'h10;
      e_tag = "R5 black";
    end
    if (m_sys != sys_sel || m_prog != prog_en) e_tag = {e_tag, " R11 pending"};
    e_hs = (m_pos == hsp);
    e_act = rdy;
    have_exp = 1;
    if (m_pos == len - 1) begin
      m_pos = 0;
      if (m_line == flen - 1) begin
        m_line = 0; m_sys = sys_sel; m_prog = prog_en;
      end else m_line++;
    end else m_pos++;
    cyc++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset byte", vid_byte, 8'h80);
    chk("R12 reset hsync", hsync, 0);
    chk("R12 reset active", active, 0);
    chk("R12 reset ready", pix_ready, 0);
    rst = 0;
    m_pos = 0; m_line = 0; m_sys = sys_sel; m_prog = prog_en;
    step();
    @(negedge clk);
    chk("R12 first byte", vid_byte, 8'hFF);
    have_exp = 1;
    step();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (i == 330)  sys_sel = 1;              // mid-frame request, R11
      if (i == 1500) prog_en = 1;
      if (i == 2400) begin sys_sel = 0; end
      if (i == 3200) prog_en = 0;
      step();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule